// File: doc/BRIEF.md
# Command-Framed SPI Slave Front End (Mode 3)

This block is the serial front end of a command-driven peripheral. The host is an SPI master that uses clock polarity 1 and clock phase 1. The block brings SCK, MOSI and the active-low select into a fast system clock through synchronizers and finds the SCK edges in that domain. It then shifts one byte in and one byte out at the same time, most significant bit first.

The first byte of a transaction is always treated as a command. While that byte is exchanged, the block answers with a fixed status byte that tells the host the slave is ready for a command. A small parameter table maps known command codes to the number of data bytes that follow the command. During those data bytes the block transmits whatever byte the core last loaded, and it marks each received byte as data rather than command. A command that is not in the table, or that has a length of zero, makes the next byte a new command.

A gap timer runs while a transfer is unfinished. If too many system-clock ticks pass without a completed byte, the block drops the partial transfer, pulses an abort flag and goes back to waiting for a command. The core logic behind the block sees one strobe per received byte, a flag telling a command byte from a data byte, a port for loading the reply byte and the abort pulse.

Top module: `spi_cmd_slave`

## Requirements
- R1: Once reset is released, `miso` is 1, `rx_valid` is 0 and `xfer_abort` is 0.
- R2: The block samples MOSI on SCK rising edges. It changes MISO only after SCK falling edges. Each byte is 8 clock pulses, most significant bit first in both directions, and `rx_data` equals the byte the master sent.
- R3: When the block is waiting for a command, the byte it returns is `IDLE_CODE` (default 0x55), and the received byte is reported with `rx_cmd` = 1.
- R4: During data bytes, the block returns the byte most recently written through `tx_load`/`tx_byte`, and the received byte is reported with `rx_cmd` = 0.
- R5: A command whose code is in the table with length N > 0 is followed by exactly N data bytes. The byte after those is a command. The default table is 0x01→2, 0x10→1, 0x20→3, 0x30→0.
- R6: A command code that is not in the table, or whose table length is 0, makes the next byte a command.
- R7: The abort works as follows.
  - It applies while data bytes are still owed.
  - If `TIMEOUT_TICKS` system clocks pass without a completed byte, `xfer_abort` pulses for one cycle.
  - Any partly shifted bits are discarded.
  - The next byte is a command.
  - The abort never happens in the same cycle as `rx_valid`.
- R8: No abort occurs while the block is waiting for a command, however long the bus is idle.
- R9: Two rules apply to the select line.
  - While `ss_n` is high, `miso` is held at 1.
  - A falling edge of `ss_n` restarts the bit count, so bits from an abandoned partial byte do not carry into the next byte.
- R10: `rx_valid` is a single-cycle pulse, issued exactly once per completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock from the master, idles high |
| mosi | input | 1 | Serial data from the master |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data to the master |
| tx_load | input | 1 | Strobe that captures `tx_byte` as the next reply byte |
| tx_byte | input | 8 | Reply byte for data phases |
| rx_valid | output | 1 | One-cycle strobe: a byte has been received |
| rx_data | output | 8 | Received byte, valid with `rx_valid` |
| rx_cmd | output | 1 | 1 when the byte under `rx_valid` is a command byte |
| xfer_abort | output | 1 | One-cycle pulse: a partial transfer was dropped on timeout |

## Verification
The bench walks the command framing through known commands of several lengths, an unknown code and a zero-length code. A design that counted data bytes wrongly would send the wrong reply byte and set the wrong `rx_cmd` flag on the next command.

It stops the host mid-transfer and also halfway through a byte so that the gap timer expires. A design that kept the stale bits or stayed in the data phase would receive the following command corrupted, or treat it as data. It also leaves the bus idle for a long time while a command is awaited, which catches a timer that runs in that state.

Finally, it abandons a partial byte by raising the select line. A bit counter that is not cleared on the select edge would misalign every later byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int LEN_W  = 4;

  typedef enum logic {
    ST_CMD  = 1'b0,
    ST_DATA = 1'b1
  } frame_state_e;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic mosi_pin,
  input  logic ss_n_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic ss_s,
  output logic ss_fall
);
  localparam int NCH = 3;

  logic [NCH-1:0] pins;
  logic [NCH-1:0] chain [STAGES];
  logic [NCH-1:0] last_q;
  logic [NCH-1:0] cur;

  assign pins = {ss_n_pin, mosi_pin, sck_pin};

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[s] <= '1;
        end else begin
          if (s == 0) chain[s] <= pins;
          else        chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '1;
    else        last_q <= cur;
  end

  assign sck_rise = cur[0] & ~last_q[0];
  assign sck_fall = ~cur[0] & last_q[0];
  assign mosi_s   = cur[1];
  assign ss_s     = cur[2];
  assign ss_fall  = ~cur[2] & last_q[2];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
  import spi_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] IDLE_CODE = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              ss_s,
  input  logic              ss_fall,
  input  logic              clr,
  input  logic              in_cmd,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] tx_sh_q, tx_sh_d;
  logic [BYTE_W-1:0] rx_sh_q, rx_sh_d;
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] rx_data_q, rx_data_d;
  logic              valid_d, valid_q;
  logic              active;

  assign active = ~ss_s;

  always_comb begin
    cnt_d     = cnt_q;
    tx_sh_d   = tx_sh_q;
    rx_sh_d   = rx_sh_q;
    rx_data_d = rx_data_q;
    valid_d   = 1'b0;
    if (ss_fall || clr) begin
      cnt_d = '0;
    end else if (active) begin
      if (sck_fall) begin
        if (cnt_q == '0) tx_sh_d = in_cmd ? IDLE_CODE : hold_q;
        else             tx_sh_d = {tx_sh_q[BYTE_W-2:0], 1'b0};
      end
      if (sck_rise) begin
        rx_sh_d = {rx_sh_q[BYTE_W-2:0], mosi_s};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(BYTE_W-1)) begin
          valid_d   = 1'b1;
          rx_data_d = {rx_sh_q[BYTE_W-2:0], mosi_s};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      tx_sh_q   <= '1;
      rx_sh_q   <= '0;
      rx_data_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      tx_sh_q   <= tx_sh_d;
      rx_sh_q   <= rx_sh_d;
      rx_data_q <= rx_data_d;
      valid_q   <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (tx_load) hold_q <= tx_byte;
  end

  assign miso     = ss_s ? 1'b1 : tx_sh_q[BYTE_W-1];
  assign rx_valid = valid_q;
  assign rx_data  = rx_data_q;
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int                      NUM_CMDS      = 4,
  parameter logic [NUM_CMDS*8-1:0]   CMD_CODES     = {8'h30, 8'h20, 8'h10, 8'h01},
  parameter logic [NUM_CMDS*4-1:0]   CMD_LENS      = {4'd0, 4'd3, 4'd1, 4'd2},
  parameter int                      TIMEOUT_TICKS = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              in_cmd,
  output logic              abort
);
  localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);

  frame_state_e     st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [NUM_CMDS-1:0] hit;
  logic [LEN_W-1:0] len_sel;

  genvar i;
  generate
    for (i = 0; i < NUM_CMDS; i++) begin : g_match
      assign hit[i] = (rx_data == CMD_CODES[i*8 +: 8]);
    end
  endgenerate

  always_comb begin
    len_sel = '0;
    for (int k = 0; k < NUM_CMDS; k++) begin
      if (hit[k]) len_sel = CMD_LENS[k*LEN_W +: LEN_W];
    end
  end

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    tmr_d = tmr_q;
    abort = 1'b0;
    case (st_q)
      ST_CMD: begin
        tmr_d = '0;
        if (rx_valid && len_sel != '0) begin
          st_d  = ST_DATA;
          rem_d = len_sel;
        end
      end
      default: begin
        if (rx_valid) begin
          tmr_d = '0;
          rem_d = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) st_d = ST_CMD;
        end else if (tmr_q == TMR_W'(TIMEOUT_TICKS - 1)) begin
          abort = 1'b1;
          st_d  = ST_CMD;
          tmr_d = '0;
          rem_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_CMD;
      rem_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      tmr_q <= tmr_d;
    end
  end

  assign in_cmd = (st_q == ST_CMD);
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int                    NUM_CMDS      = 4,
  parameter logic [NUM_CMDS*8-1:0] CMD_CODES     = {8'h30, 8'h20, 8'h10, 8'h01},
  parameter logic [NUM_CMDS*4-1:0] CMD_LENS      = {4'd0, 4'd3, 4'd1, 4'd2},
  parameter int                    TIMEOUT_TICKS = 10_000_000,
  parameter logic [7:0]            IDLE_CODE     = 8'h55,
  parameter int                    SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       ss_n,
  output logic       miso,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_cmd,
  output logic       xfer_abort
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       sck_rise, sck_fall, mosi_s, ss_s, ss_fall;
  logic       in_cmd, abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sck_pin  (sck),
    .mosi_pin (mosi),
    .ss_n_pin (ss_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .ss_s     (ss_s),
    .ss_fall  (ss_fall)
  );

  spi_cmd_shift #(.IDLE_CODE(IDLE_CODE)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .ss_s     (ss_s),
    .ss_fall  (ss_fall),
    .clr      (abort),
    .in_cmd   (in_cmd),
    .tx_load  (tx_load),
    .tx_byte  (tx_byte),
    .miso     (miso),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  spi_cmd_ctrl #(
    .NUM_CMDS      (NUM_CMDS),
    .CMD_CODES     (CMD_CODES),
    .CMD_LENS      (CMD_LENS),
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .in_cmd   (in_cmd),
    .abort    (abort)
  );

  assign rx_cmd     = in_cmd;
  assign xfer_abort = abort;
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk #(
  parameter int                    NUM_CMDS = 4,
  parameter logic [NUM_CMDS*8-1:0] CMD_CODES = {8'h30, 8'h20, 8'h10, 8'h01},
  parameter logic [NUM_CMDS*4-1:0] CMD_LENS  = {4'd0, 4'd3, 4'd1, 4'd2}
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       ss_n,
  input logic       miso,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_cmd,
  input logic       xfer_abort
);
  logic [3:0] exp_len;
  always_comb begin
    exp_len = '0;
    for (int k = 0; k < NUM_CMDS; k++) begin
      if (rx_data == CMD_CODES[k*8 +: 8]) exp_len = CMD_LENS[k*4 +: 4];
    end
  end

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_abort_in_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |-> !rx_cmd);

  p_abort_to_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_abort |=> rx_cmd);

  p_abort_no_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_abort && rx_valid));

  p_short_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_cmd && exp_len == 4'd0) |=> rx_cmd);

  p_long_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_cmd && exp_len != 4'd0) |=> !rx_cmd);

  p_miso_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3)) |-> miso);

  p_miso_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && !$past(ss_n) && !$past(ss_n, 2) && !$past(ss_n, 3) && !$past(ss_n, 4)
     && !$past(ss_n, 5) && sck && $past(sck) && $past(sck, 2) && $past(sck, 3)
     && $past(sck, 4) && $past(sck, 5)) |-> $stable(miso));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk #(
  .NUM_CMDS  (NUM_CMDS),
  .CMD_CODES (CMD_CODES),
  .CMD_LENS  (CMD_LENS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .ss_n       (ss_n),
  .miso       (miso),
  .rx_valid   (rx_valid),
  .rx_data    (rx_data),
  .rx_cmd     (rx_cmd),
  .xfer_abort (xfer_abort)
);

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;
  localparam int HALF = 8;
  localparam int TMO  = 400;
  localparam int NVEC = 12;
  // vector: {mosi byte, expect-command flag, reply byte loaded before data bytes}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h01, 1'b1, 8'h00}, {8'hA1, 1'b0, 8'h3C}, {8'hA2, 1'b0, 8'hC3},
    {8'h7E, 1'b1, 8'h00}, {8'h10, 1'b1, 8'h00}, {8'h00, 1'b0, 8'h96},
    {8'h30, 1'b1, 8'h00}, {8'h20, 1'b1, 8'h00}, {8'h5A, 1'b0, 8'h01},
    {8'hFF, 1'b0, 8'h80}, {8'h81, 1'b0, 8'hFF}, {8'h01, 1'b1, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1, mosi = 1'b1, ss_n = 1'b1, tx_load = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic miso, rx_valid, rx_cmd, xfer_abort;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, n_valid = 0, n_abort = 0;
  logic [7:0] last_data = 8'h00;
  logic last_cmd = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_cmd_slave #(.TIMEOUT_TICKS(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_cmd(rx_cmd), .xfer_abort(xfer_abort)
  );

  always @(posedge clk) begin
    if (rx_valid) begin
      n_valid   <= n_valid + 1;
      last_data <= rx_data;
      last_cmd  <= rx_cmd;
    end
    if (xfer_abort) n_abort <= n_abort + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] b);
    @(negedge clk); tx_byte = b; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk); sck = 1'b0; mosi = mo[7-b];
      wait_clk(HALF);
      mi = {mi[6:0], miso};
      sck = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    @(negedge clk); ss_n = 1'b0;
    wait_clk(HALF);
    send_bits(mo, 8, mi);
    ss_n = 1'b1;
    wait_clk(40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    int v0, a0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check("R1 miso", miso, 1);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 abort", xfer_abort, 0);

    // R2 R3 R4 R5 R6 R10: table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] mo, tx;
      logic iscmd;
      {mo, iscmd, tx} = VEC[i];
      if (!iscmd) load_tx(tx);
      v0 = n_valid;
      spi_byte(mo, mi);
      check("R2 rx_data", last_data, mo);
      check("R10 one strobe", n_valid - v0, 1);
      if (iscmd) begin
        check("R3 idle reply", mi, 8'h55);
        check("R5 R6 cmd flag", last_cmd, 1);
      end else begin
        check("R4 data reply", mi, tx);
        check("R5 data flag", last_cmd, 0);
      end
    end

    // R7: timeout between bytes of cmd 0x01 (one data byte of two sent)
    load_tx(8'h77);
    spi_byte(8'h5A, mi);
    check("R4 data reply", mi, 8'h77);
    a0 = n_abort;
    wait_clk(TMO + 200);
    check("R7 abort pulse", n_abort - a0, 1);
    spi_byte(8'h30, mi);
    check("R7 fresh cmd reply", mi, 8'h55);
    check("R7 fresh cmd flag", last_cmd, 1);

    // R8: long idle while waiting for a command
    a0 = n_abort;
    wait_clk(TMO * 2);
    check("R8 no abort", n_abort - a0, 0);

    // R7: timeout mid-byte discards partial bits
    spi_byte(8'h20, mi);
    @(negedge clk); ss_n = 1'b0;
    wait_clk(HALF);
    a0 = n_abort;
    send_bits(8'hE0, 3, mi);
    wait_clk(TMO + 200);
    check("R7 partial abort", n_abort - a0, 1);
    ss_n = 1'b1;
    wait_clk(40);
    check("R9 miso idle", miso, 1);
    v0 = n_valid;
    spi_byte(8'h30, mi);
    check("R7 after discard data", last_data, 8'h30);
    check("R7 after discard reply", mi, 8'h55);
    check("R7 after discard flag", last_cmd, 1);
    check("R10 one strobe", n_valid - v0, 1);

    // R9: select released mid-byte restarts bit count
    @(negedge clk); ss_n = 1'b0;
    wait_clk(HALF);
    send_bits(8'hFF, 3, mi);
    ss_n = 1'b1;
    wait_clk(20);
    check("R9 miso high", miso, 1);
    v0 = n_valid;
    spi_byte(8'h10, mi);
    check("R9 realigned", last_data, 8'h10);
    check("R9 one strobe", n_valid - v0, 1);
    check("R9 reply", mi, 8'h55);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule